// File: doc/BRIEF.md
# Radix-4 Recoded Multiplier

This block is a purely combinational multiplier for two N-bit operands. One input selects whether both operands are read as unsigned numbers or as two's-complement numbers, and the output is always the full 2N-bit product. It is meant to sit inside a datapath that registers its inputs and outputs elsewhere. Pipelining is left to the surrounding logic.

The multiplier operand is recoded in overlapping three-bit windows that step by two bit positions. A group of decode outputs for each window picks a partial product of zero, one times the multiplicand or twice the multiplicand, and says whether that value is negated. A negated row is formed by bit inversion. The missing +1 is placed in the free low positions of the next row's vector, and the last row's +1 goes into the constant vector. Sign extension of every row is replaced by one precomputed constant vector, with each row's top bit inverted. The rows and the constant are folded by a linear chain of 3:2 carry-save stages. One carry-propagate addition then produces the result. In unsigned mode the multiplier is padded with two zero bits, which adds one more row. In signed mode that row is forced to zero.

Top module: `booth_mul`

## Requirements
- R1: Window r takes multiplier bits (2r+1, 2r, 2r-1), with bit -1 read as 0. Codes 000 and 111 select zero. Codes 001 and 010 select +Y, 011 selects +2Y, 100 selects -2Y, and 101 and 110 select -Y.
- R2: For each window, at most one of the "one times" and "twice" selects is active. The negate flag is active exactly for codes whose top bit is 1.
- R3: The multiplicand is widened to N+1 bits. The top bit is 0 in unsigned mode and a copy of the sign bit in signed mode, so that 2Y and the most negative value are represented exactly.
- R4: With `signed_mode`=0, `product` equals the unsigned product of `mcand` and `mplier`, all 2N bits.
- R5: With `signed_mode`=1, `product` equals the two's-complement product of `mcand` and `mplier`, all 2N bits.
- R6: In signed mode the extra top window (N/2+1-th row) selects zero, including for the most negative multiplier.
- R7: Each carry-save stage preserves the sum of its three inputs modulo 2^(2N).
- R8: A negated row gets its +1 at its own least significant weight, carried in the next row's vector. Multipliers made of long runs of ones or of alternating bits produce exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier, the recoded operand |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| product | output | 2N | Full-width product |

## Verification
A wrong decode or select in a single window shifts the product by a fixed multiple of the multiplicand times a power of four. The error shows at `product` in the same evaluation, but only for multiplier values that contain that window code. For this reason the small configuration is swept over every operand pair in both modes. A missing +1 or a wrong sign-extension constant leaves the result off by a small power-of-two offset whenever any row is negated. Runs of ones and the most negative operands expose it at once.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef struct packed {
        logic one;
        logic two;
        logic neg;
    } bsel_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
    import booth_pkg::*;
(
    input  logic [2:0] grp,
    output bsel_t      sel
);
    bsel_t sel_d;

    always_comb begin
        sel_d = '0;
        unique case (grp)
            3'b001, 3'b010: sel_d.one = 1'b1;
            3'b011:         sel_d.two = 1'b1;
            3'b100: begin
                sel_d.two = 1'b1;
                sel_d.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                sel_d.one = 1'b1;
                sel_d.neg = 1'b1;
            end
            3'b111:         sel_d.neg = 1'b1;
            default:        sel_d = '0;
        endcase
    end

    assign sel = sel_d;

    always_comb begin
        a_r2_select_exclusive: assert (!(sel.one && sel.two))
            else $error("R2: one and two selects both active");
        a_r1_zero_codes: assert (!((grp == 3'b000) || (grp == 3'b111)) || !(sel.one || sel.two))
            else $error("R1: zero code selected a nonzero row");
        a_r2_neg_flag: assert (sel.neg == grp[2])
            else $error("R2: negate flag does not follow window top bit");
    end
endmodule

// File: rtl/booth_row.sv
module booth_row
    import booth_pkg::*;
#(
    parameter int N = 16,
    localparam int W = N + 2
) (
    input  logic [N:0]   yext,
    input  bsel_t        sel,
    output logic [W-1:0] row_bits
);
    logic [W-1:0] mag_d;
    logic [W-1:0] val_d;

    always_comb begin
        mag_d = '0;
        if (sel.one) begin
            mag_d = {yext[N], yext};
        end else if (sel.two) begin
            mag_d = {yext, 1'b0};
        end
        val_d = sel.neg ? ~mag_d : mag_d;
    end

    // top bit inverted: the sign extension is folded into a constant row
    assign row_bits = {~val_d[W-1], val_d[W-2:0]};
endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    always_comb begin
        s    = x ^ y ^ z;
        c    = '0;
        for (int i = 0; i < W - 1; i++) begin
            c[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
        end
    end

    always_comb begin
        a_r7_csa_keeps_sum: assert (W'(s + c) == W'(x + y + z))
            else $error("R7: carry-save stage changed the sum");
    end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    input  logic           signed_mode,
    output logic [2*N-1:0] product
);
    localparam int ROWS = N / 2 + 1;
    localparam int W    = N + 2;
    localparam int PW   = 2 * N;
    localparam int VECS = ROWS + 1;

    function automatic logic [PW-1:0] sign_const();
        logic [PW-1:0] acc;
        acc = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (2 * i + W - 1 < PW) begin
                acc = acc + (PW'(1) << (2 * i + W - 1));
            end
        end
        return PW'(-acc);
    endfunction

    localparam logic [PW-1:0] KSIGN = sign_const();

    logic [N+2:0]  xe;
    logic [N:0]    yext;
    bsel_t         sel  [ROWS];
    logic [W-1:0]  pp   [ROWS];
    logic [PW-1:0] vec  [VECS];
    logic [PW-1:0] s_ch [VECS];
    logic [PW-1:0] c_ch [VECS];

    assign xe   = {2'b00, mplier, 1'b0};
    assign yext = {signed_mode & mcand[N-1], mcand};

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [2:0] grp;
        if (r == ROWS - 1) begin : g_top
            assign grp = signed_mode ? 3'b000 : xe[2*r+2:2*r];
        end else begin : g_mid
            assign grp = xe[2*r+2:2*r];
        end

        booth_enc i_enc (
            .grp (grp),
            .sel (sel[r])
        );

        booth_row #(.N(N)) i_row (
            .yext     (yext),
            .sel      (sel[r]),
            .row_bits (pp[r])
        );

        if (r == 0) begin : g_first
            assign vec[r] = PW'(pp[r]);
        end else begin : g_next
            assign vec[r] = (PW'(pp[r]) << (2 * r))
                          | (PW'(sel[r-1].neg) << (2 * (r - 1)));
        end
    end

    assign vec[ROWS] = KSIGN | (PW'(sel[ROWS-1].neg) << (2 * (ROWS - 1)));

    assign s_ch[0] = '0;
    assign c_ch[0] = '0;
    assign s_ch[1] = vec[0];
    assign c_ch[1] = vec[1];

    for (genvar k = 2; k < VECS; k++) begin : g_csa
        csa_stage #(.W(PW)) i_csa (
            .x (s_ch[k-1]),
            .y (c_ch[k-1]),
            .z (vec[k]),
            .s (s_ch[k]),
            .c (c_ch[k])
        );
    end

    assign product = s_ch[VECS-1] + c_ch[VECS-1];

    logic [PW-1:0] ref_d;
    always_comb begin
        if (signed_mode) begin
            ref_d = PW'({{N{mcand[N-1]}}, mcand} * {{N{mplier[N-1]}}, mplier});
        end else begin
            ref_d = PW'({{N{1'b0}}, mcand} * {{N{1'b0}}, mplier});
        end
        a_r4_r5_exact_product: assert (product == ref_d)
            else $error("R4/R5: product mismatch");
        a_r6_top_row_zero: assert (!signed_mode || (!sel[ROWS-1].one && !sel[ROWS-1].two && !sel[ROWS-1].neg))
            else $error("R6: top window active in signed mode");
    end
endmodule

// File: tb/test_booth_mul.sv
`timescale 1ns/1ps
module test_booth_mul;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [15:0] a16, b16;
    logic [31:0] p16;
    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic        mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    booth_mul #(.N(16)) i_booth_mul (
        .mcand (a16), .mplier (b16), .signed_mode (mode), .product (p16)
    );

    booth_mul #(.N(8)) i_booth_mul_small (
        .mcand (a8), .mplier (b8), .signed_mode (mode), .product (p8)
    );

    function automatic logic [31:0] exp16(input logic m, input logic [15:0] x, input logic [15:0] y);
        longint sx, sy;
        sx = (m && x[15]) ? longint'(x) - 65536 : longint'(x);
        sy = (m && y[15]) ? longint'(y) - 65536 : longint'(y);
        return 32'(sx * sy);
    endfunction

    function automatic logic [15:0] exp8(input logic m, input logic [7:0] x, input logic [7:0] y);
        int sx, sy;
        sx = (m && x[7]) ? int'(x) - 256 : int'(x);
        sy = (m && y[7]) ? int'(y) - 256 : int'(y);
        return 16'(sx * sy);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
        total++;
        if (got !== want) begin
            bad++;
            if (bad <= 20)
                $display("FAIL %s: mode=%0d a16=%h b16=%h a8=%h b8=%h got=%h exp=%h",
                         tag, mode, a16, b16, a8, b8, got, want);
        end
    endtask

    task automatic dir16(input string tag, input logic m, input logic [15:0] x, input logic [15:0] y);
        @(negedge clk);
        mode = m; a16 = x; b16 = y;
        #1;
        check(tag, p16, exp16(m, x, y));
    endtask

    initial begin
        mode = 1'b0; a16 = '0; b16 = '0; a8 = '0; b8 = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset-state zero product", p16, 32'h0);
        rst_n = 1'b1;

        // R1: codes 001/010 (+Y) and 011/100 (+-2Y) and 101/110 (-Y)
        dir16("R1", 1'b0, 16'h0003, 16'h5555);
        dir16("R1", 1'b1, 16'hFFFD, 16'h5555);
        dir16("R2", 1'b0, 16'hFFFF, 16'h6666);
        dir16("R2", 1'b1, 16'h7FFF, 16'h9999);
        // R3: widened multiplicand, most negative value and 2Y
        dir16("R3", 1'b0, 16'h8000, 16'h0002);
        dir16("R3", 1'b1, 16'h8000, 16'h0002);
        dir16("R3", 1'b1, 16'h8000, 16'h0003);
        // R6: top window suppressed in signed mode
        dir16("R6", 1'b1, 16'h8000, 16'h8000);
        dir16("R6", 1'b1, 16'h7FFF, 16'hFFFF);
        dir16("R6", 1'b0, 16'h8000, 16'h8000);
        // R7/R8: negated rows everywhere, all carries live
        dir16("R7", 1'b0, 16'hFFFF, 16'hFFFF);
        dir16("R8", 1'b1, 16'hFFFF, 16'hFFFF);
        dir16("R8", 1'b0, 16'h1234, 16'hAAAA);
        dir16("R8", 1'b1, 16'h1234, 16'hAAAA);
        dir16("R8", 1'b0, 16'h0001, 16'hFFFE);

        // exhaustive sweep at N=8 with random N=16 alongside
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    @(negedge clk);
                    mode = m[0];
                    a8 = 8'(x); b8 = 8'(y);
                    a16 = 16'($urandom); b16 = 16'($urandom);
                    #1;
                    check(m ? "R5 N=8 sweep" : "R4 N=8 sweep", {16'h0, p8}, {16'h0, exp8(m[0], a8, b8)});
                    check(m ? "R5 N=16 random" : "R4 N=16 random", p16, exp16(m[0], a16, b16));
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule